// File: doc/BRIEF.md
# Auto-Rate Acquisition Sequencer

This block is the slow-clock controller of a clock-recovery loop that can work at several line rates. It runs on the chip clock, and it moves forward only on a one-cycle system tick. From a 2-bit rate code it picks the feedback divider modulus (1, 2 or 4) and the VCO band (low or high). It also drives the sweep-direction and sweep-active controls of an external analog frequency sweep. The VCO, the charge pump and the loop filter are not part of this block.

In automatic mode, an internal 2-bit rate counter supplies the rate code, and the counter is shown on the rate indication output. Each acquisition cycle sweeps up, then sweeps down, then waits one idle tick. The counter steps only after a whole cycle has passed without lock. In manual mode the external rate-select word supplies the code, and the counter never moves. When input data goes away, the counter holds its value, so the next acquisition starts at the last rate that was in use. Two locked ticks in a row stop the sweep.

Top module: `rateAcqSeq`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the rate counter to code 0 and drives `sweepActive` and `sweepUp` low.
- R2: With `stdRate`=1, the rate code selects a divider and band as follows: code 0 gives divide-by-4 on the high band, code 1 divide-by-2 low, code 2 divide-by-2 high, and code 3 divide-by-1 low. `divMod` carries the modulus as the value 1, 2 or 4. `bandHigh`=1 means the high band.
- R3: With `stdRate`=0, codes 0 and 1 give divide-by-4 and codes 2 and 3 give divide-by-2, all on the high band. The low band is chosen only when `stdRate`=1 and bit 0 of the code is 1.
- R4: With `autoMode`=0, `rateInd` and the decode follow `rateSel`, and the internal counter never advances. When `autoMode` returns to 1, `rateInd` shows the counter value that was held.
- R5: With `autoMode`=1, `rateInd` shows the counter. The counter goes up by one, wrapping from 3 to 0, only on the tick that ends a failed acquisition cycle.
- R6: While data is present and there is no lock, each acquisition cycle is `HALF_TICKS` ticks with `sweepActive`=1 and `sweepUp`=1, then `HALF_TICKS` ticks with `sweepActive`=1 and `sweepUp`=0, then one tick with `sweepActive`=0.
- R7: `phaseLocked` seen on two consecutive ticks with data present stops the sweep (`sweepActive`=0) and holds the counter. If only one locked tick is seen, the next tick restarts the upward sweep at the same code.
- R8: A tick with `dataPresent`=0 stops the sweep and freezes the counter. The first tick after data returns starts an upward sweep at the code that was held.
- R9: `sweepUp`, `sweepActive` and the counter change only at clock edges where `tick`=1.
- R10: In the locked state, a tick with `phaseLocked`=0 restarts the upward sweep at the same code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle system-clock tick enable |
| autoMode | input | 1 | 1 = automatic rate search, 0 = manual rate |
| stdRate | input | 1 | Selects the standard-rate decode table |
| rateSel | input | 2 | Rate code used in manual mode |
| dataPresent | input | 1 | Input transitions are being detected |
| phaseLocked | input | 1 | The loop reports phase lock |
| divMod | output | 3 | Feedback divider modulus: 1, 2 or 4 |
| bandHigh | output | 1 | 1 = high VCO band, 0 = low band |
| rateInd | output | 2 | Rate code in effect |
| sweepUp | output | 1 | Sweep direction, registered (1 = upward) |
| sweepActive | output | 1 | Sweep running, registered |

## Verification
Four properties hold on every cycle: the divider value is always a legal single modulus, the low band and divide-by-1 occur only for the codes allowed, the sweep outputs and the counter stay still at edges without a tick, and any change of the automatic code is a step of exactly one. Some behaviour appears only across several ticks, and only the bench scenarios can show it. That covers the length of each sweep phase, where the counter advances inside the cycle, the two-tick lock confirmation and its failure path, the counter held through data loss and manual mode, and the restart after lock is lost.

// File: rtl/rateAcqPkg.sv
package rateAcqPkg;

  localparam int RATE_W = 2;

  typedef enum logic [2:0] {
    ST_NODATA  = 3'd0,
    ST_UP      = 3'd1,
    ST_DOWN    = 3'd2,
    ST_GAP     = 3'd3,
    ST_CONFIRM = 3'd4,
    ST_LOCKED  = 3'd5
  } acqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic stepRate;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [2:0] divMod;
    logic       bandHigh;
  } rateDecode_t;

  function automatic rateDecode_t decodeRate(input logic stdRate,
                                             input logic [RATE_W-1:0] code);
    rateDecode_t d;
    d.bandHigh = !(stdRate && code[0]);
    if (stdRate) begin
      case (code)
        2'd0:    d.divMod = 3'd4;
        2'd1:    d.divMod = 3'd2;
        2'd2:    d.divMod = 3'd2;
        default: d.divMod = 3'd1;
      endcase
    end else begin
      d.divMod = code[1] ? 3'd2 : 3'd4;
    end
    return d;
  endfunction

endpackage

// File: rtl/rateAcqCtrl.sv
module rateAcqCtrl
  import rateAcqPkg::*;
#(
  parameter int HALF_TICKS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        dataPresent,
  input  logic        phaseLocked,
  output ctrlStrobe_t strobe,
  output logic        sweepUp,
  output logic        sweepActive
);

  localparam int CNT_W = $clog2(HALF_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HALF_TICKS - 1);

  acqState_t state, nextState;
  logic [CNT_W-1:0] phaseCnt, nextCnt;

  always_comb begin
    nextState = state;
    nextCnt   = phaseCnt;
    strobe    = '0;
    if (!dataPresent) begin
      nextState = ST_NODATA;
      nextCnt   = '0;
    end else begin
      case (state)
        ST_NODATA: begin
          nextState = ST_UP;
          nextCnt   = '0;
        end
        ST_UP, ST_DOWN: begin
          if (phaseLocked) begin
            nextState = ST_CONFIRM;
            nextCnt   = '0;
          end else if (phaseCnt == LAST_CNT) begin
            nextState = (state == ST_UP) ? ST_DOWN : ST_GAP;
            nextCnt   = '0;
          end else begin
            nextCnt = phaseCnt + 1'b1;
          end
        end
        ST_GAP: begin
          nextCnt = '0;
          if (phaseLocked) begin
            nextState = ST_CONFIRM;
          end else begin
            nextState       = ST_UP;
            strobe.stepRate = tick;
          end
        end
        ST_CONFIRM: begin
          nextCnt   = '0;
          nextState = phaseLocked ? ST_LOCKED : ST_UP;
        end
        ST_LOCKED: begin
          nextCnt   = '0;
          if (!phaseLocked) nextState = ST_UP;
        end
        default: begin
          nextState = ST_NODATA;
          nextCnt   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_NODATA;
      phaseCnt    <= '0;
      sweepUp     <= 1'b0;
      sweepActive <= 1'b0;
    end else if (tick) begin
      state       <= nextState;
      phaseCnt    <= nextCnt;
      sweepUp     <= (nextState == ST_UP);
      sweepActive <= (nextState == ST_UP) || (nextState == ST_DOWN);
    end
  end

endmodule

// File: rtl/rateAcqPath.sv
module rateAcqPath
  import rateAcqPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              autoMode,
  input  logic              stdRate,
  input  logic [RATE_W-1:0] rateSel,
  input  ctrlStrobe_t       strobe,
  output logic [2:0]        divMod,
  output logic              bandHigh,
  output logic [RATE_W-1:0] rateInd
);

  logic [RATE_W-1:0] rateCnt;
  rateDecode_t       dec;

  // counter holds in manual mode and whenever no step is strobed
  always_ff @(posedge clk) begin
    if (rst)                            rateCnt <= '0;
    else if (strobe.stepRate && autoMode) rateCnt <= rateCnt + 1'b1;
  end

  always_comb begin
    rateInd  = autoMode ? rateCnt : rateSel;
    dec      = decodeRate(stdRate, rateInd);
    divMod   = dec.divMod;
    bandHigh = dec.bandHigh;
  end

endmodule

// File: rtl/rateAcqSeq.sv
module rateAcqSeq
  import rateAcqPkg::*;
#(
  parameter int HALF_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       autoMode,
  input  logic       stdRate,
  input  logic [1:0] rateSel,
  input  logic       dataPresent,
  input  logic       phaseLocked,
  output logic [2:0] divMod,
  output logic       bandHigh,
  output logic [1:0] rateInd,
  output logic       sweepUp,
  output logic       sweepActive
);

  ctrlStrobe_t strobe;

  rateAcqCtrl #(.HALF_TICKS(HALF_TICKS)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .dataPresent (dataPresent),
    .phaseLocked (phaseLocked),
    .strobe      (strobe),
    .sweepUp     (sweepUp),
    .sweepActive (sweepActive)
  );

  rateAcqPath u_path (
    .clk      (clk),
    .rst      (rst),
    .autoMode (autoMode),
    .stdRate  (stdRate),
    .rateSel  (rateSel),
    .strobe   (strobe),
    .divMod   (divMod),
    .bandHigh (bandHigh),
    .rateInd  (rateInd)
  );

endmodule

// File: rtl/rateAcqSeqChecker.sv
module rateAcqSeqChecker (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       autoMode,
  input logic       stdRate,
  input logic [2:0] divMod,
  input logic       bandHigh,
  input logic [1:0] rateInd,
  input logic       sweepUp,
  input logic       sweepActive
);

  // R2 R3: modulus is always exactly one of 1, 2, 4
  a_r2_div_legal: assert property (@(posedge clk) disable iff (rst)
    $onehot(divMod));

  // R3: low band only for standard table with code bit 0 set
  a_r3_low_band_codes: assert property (@(posedge clk) disable iff (rst)
    !bandHigh |-> (stdRate && rateInd[0]));

  // R2: divide-by-1 only for standard table code 3
  a_r2_div1_code: assert property (@(posedge clk) disable iff (rst)
    (divMod == 3'd1) |-> (stdRate && rateInd == 2'd3));

  // R9: sweep controls hold across edges without a tick
  a_r9_sweep_tick_only: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable({sweepUp, sweepActive}));

  // R9 R5: automatic code holds across edges without a tick
  a_r9_rate_tick_only: assert property (@(posedge clk) disable iff (rst)
    (autoMode && !tick) ##1 autoMode |-> $stable(rateInd));

  // R5: automatic code only ever steps by one
  a_r5_step_by_one: assert property (@(posedge clk) disable iff (rst)
    autoMode ##1 (autoMode && !$stable(rateInd)) |->
      rateInd == 2'($past(rateInd) + 2'd1));

  // R6: downward sweep never shown while inactive flag implies up
  a_r6_up_needs_active: assert property (@(posedge clk) disable iff (rst)
    sweepUp |-> sweepActive);

endmodule

bind rateAcqSeq rateAcqSeqChecker u_rateAcqSeqChecker (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .autoMode    (autoMode),
  .stdRate     (stdRate),
  .divMod      (divMod),
  .bandHigh    (bandHigh),
  .rateInd     (rateInd),
  .sweepUp     (sweepUp),
  .sweepActive (sweepActive)
);

// File: tb/rateAcqSeq_bench.sv
`timescale 1ns/1ps
module rateAcqSeq_bench;

  localparam int HALF  = 3;
  localparam int CYCLE = 2 * HALF + 1;

  logic       clk = 1'b0;
  logic       rst, tick, autoMode, stdRate, dataPresent, phaseLocked;
  logic [1:0] rateSel;
  logic [2:0] divMod;
  logic       bandHigh, sweepUp, sweepActive;
  logic [1:0] rateInd;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rateAcqSeq #(.HALF_TICKS(HALF)) u_rateAcqSeq (
    .clk(clk), .rst(rst), .tick(tick), .autoMode(autoMode), .stdRate(stdRate),
    .rateSel(rateSel), .dataPresent(dataPresent), .phaseLocked(phaseLocked),
    .divMod(divMod), .bandHigh(bandHigh), .rateInd(rateInd),
    .sweepUp(sweepUp), .sweepActive(sweepActive)
  );

  // {stdRate, rateSel[1:0], divMod[2:0], bandHigh}
  localparam logic [6:0] DEC_VEC [8] = '{
    {1'b1, 2'd0, 3'd4, 1'b1}, {1'b1, 2'd1, 3'd2, 1'b0},
    {1'b1, 2'd2, 3'd2, 1'b1}, {1'b1, 2'd3, 3'd1, 1'b0},
    {1'b0, 2'd0, 3'd4, 1'b1}, {1'b0, 2'd1, 3'd4, 1'b1},
    {1'b0, 2'd2, 3'd2, 1'b1}, {1'b0, 2'd3, 3'd2, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doTick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) doTick();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick = 1'b0; autoMode = 1'b0; stdRate = 1'b1;
    rateSel = 2'd0; dataPresent = 1'b0; phaseLocked = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // table walk: manual decode, R2 and R3 (R4 path)
    for (int v = 0; v < 8; v++) begin
      stdRate = DEC_VEC[v][6];
      rateSel = DEC_VEC[v][5:4];
      @(negedge clk);
      chk($sformatf("R2/R3 div v%0d", v), divMod, DEC_VEC[v][3:1]);
      chk($sformatf("R2/R3 band v%0d", v), bandHigh, DEC_VEC[v][0]);
      chk($sformatf("R4 ind v%0d", v), rateInd, DEC_VEC[v][5:4]);
    end

    // R1: reset state seen in auto mode
    autoMode = 1'b1; stdRate = 1'b1;
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    chk("R1 rateInd", rateInd, 0);
    chk("R1 sweepActive", sweepActive, 0);
    chk("R1 sweepUp", sweepUp, 0);

    // R6: one failed acquisition cycle
    dataPresent = 1'b1;
    doTick();
    chk("R6 up active", sweepActive, 1);
    chk("R6 up dir", sweepUp, 1);
    ticks(HALF - 1);
    chk("R6 still up", sweepUp, 1);
    doTick();
    chk("R6 down active", sweepActive, 1);
    chk("R6 down dir", sweepUp, 0);
    ticks(HALF - 1);
    chk("R6 still down", sweepUp, 0);
    doTick();
    chk("R6 gap inactive", sweepActive, 0);
    chk("R5 no step before gap ends", rateInd, 0);
    doTick();
    chk("R5 step to 1", rateInd, 1);
    chk("R6 restart up", sweepUp, 1);
    chk("R2 code1 div", divMod, 2);
    chk("R2 code1 band", bandHigh, 0);

    ticks(CYCLE);
    chk("R5 step to 2", rateInd, 2);
    ticks(CYCLE);
    chk("R5 step to 3", rateInd, 3);
    chk("R2 code3 div", divMod, 1);
    ticks(CYCLE);
    chk("R5 wrap to 0", rateInd, 0);
    chk("R5 wrap div", divMod, 4);
    chk("R5 wrap band", bandHigh, 1);

    // R9: input changes between ticks do nothing
    dataPresent = 1'b0; phaseLocked = 1'b1;
    repeat (3) @(negedge clk);
    dataPresent = 1'b1; phaseLocked = 1'b0;
    @(negedge clk);
    chk("R9 active held", sweepActive, 1);
    chk("R9 dir held", sweepUp, 1);
    chk("R9 rate held", rateInd, 0);

    // R7: single locked tick then loss restarts upward
    phaseLocked = 1'b1; doTick();
    chk("R7 confirm stops sweep", sweepActive, 0);
    phaseLocked = 1'b0; doTick();
    chk("R7 failed confirm up", sweepUp, 1);
    chk("R7 failed confirm code", rateInd, 0);

    // R7: two locked ticks hold lock
    phaseLocked = 1'b1; ticks(2);
    chk("R7 locked inactive", sweepActive, 0);
    ticks(CYCLE + 3);
    chk("R7 locked inactive later", sweepActive, 0);
    chk("R7 locked code held", rateInd, 0);

    // R10: lock lost restarts at same code
    phaseLocked = 1'b0; doTick();
    chk("R10 restart up", sweepUp, 1);
    chk("R10 restart active", sweepActive, 1);
    chk("R10 code kept", rateInd, 0);
    ticks(CYCLE);
    chk("R5 step after restart", rateInd, 1);

    // R8: data loss freezes counter
    dataPresent = 1'b0; doTick();
    chk("R8 sweep off", sweepActive, 0);
    ticks(3 * CYCLE);
    chk("R8 code frozen", rateInd, 1);
    dataPresent = 1'b1; doTick();
    chk("R8 resume up", sweepUp, 1);
    chk("R8 resume code", rateInd, 1);

    // R4: manual mode ignores counter stepping
    autoMode = 1'b0; rateSel = 2'd2; stdRate = 1'b1;
    @(negedge clk);
    chk("R4 manual ind", rateInd, 2);
    ticks(3 * CYCLE);
    chk("R4 manual ind held", rateInd, 2);
    chk("R4 manual div", divMod, 2);
    chk("R4 manual band", bandHigh, 1);
    autoMode = 1'b1;
    @(negedge clk);
    chk("R4 counter retained", rateInd, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule